// File: doc/BRIEF.md
# Multiplexed Host Bus Controller

This block is a bus master for single read and write accesses to external devices over one shared address/data bus. A request on the host port is accepted when the controller is ready. The controller then spends one clock in an address phase, with the address on the shared pins and a one-clock address-latch-enable pulse so that an external latch can capture it. A data phase follows on the same pins. For a write, the controller drives the write data. For a read, it releases the pins and samples what the device returns.

The length of the data phase comes from a coarse 2-bit field and a fine 1-bit correction. Reads and writes have separate settings. The read or write strobe stays low for the whole data phase, so longer settings move its deasserting edge later. A configuration code selects how many chip selects are used: none, two or four. The selected line is decoded from the top address bits. After each access, a programmable idle gap holds off the next request. When rate adjustment is enabled and more than one chip select is in use, the gap is one clock longer. A burst enable is accepted as an input but never acted on. When it is combined with non-zero wait settings, the block raises a configuration error.

The data width is a parameter (8 or 16 bits); data uses the low bits of the shared bus. All configuration is captured when a request is accepted.

Top module: `hbus_mux_ctrl`

## Requirements
- R1: After reset `rdy_o`=1, `ale_o`=0, `rd_n_o`=1, `wr_n_o`=1, `cs_n_o`=4'b1111, `ack_o`=0 and `ad_oe_o`=0.
- R2: A request is accepted on a clock edge where `req_i`=1 and `rdy_o`=1. In the next cycle, and only in that cycle, `ale_o` is 1, `ad_o` equals `addr_i` and `ad_oe_o`=1.
- R3: The data phase starts in the cycle right after the address-latch cycle. The strobe (`wr_n_o` for writes, `rd_n_o` for reads, the other strobe staying 1) is low for exactly 2*coarse + 2 - fine consecutive cycles, which is 1 to 8 cycles. Reads use the read fields and writes use the write fields.
- R4: During a write data phase `ad_oe_o`=1 and `ad_o` carries the write data, zero-extended from DATA_W bits. During a read data phase `ad_oe_o`=0.
- R5: The controller samples `ad_i[DATA_W-1:0]` at the edge that ends the read strobe. `ack_o` is high for exactly one cycle, the cycle after the last strobe cycle, and for reads `rdata_o` holds the sampled value in that cycle.
- R6: The chip-select code {`cfg_cs_sel_i`, `cfg_cs_ext_i`} sets the mode. {3,0} gives two selects: `cs_n_o[addr[ADDR_W-1]]` is low. {0,1} gives four selects: `cs_n_o[addr[ADDR_W-1:ADDR_W-2]]` is low. Every other code gives no select. At most one line is low, only during the address and data phases; all lines are high otherwise.
- R7: After the ack cycle, `rdy_o` stays low for G further cycles, counting the ack cycle as the first. G = `cfg_gap_i`, plus 1 when `cfg_rate_adj_i`=1 and the mode uses two or four selects. With G=0, `rdy_o` is 1 in the ack cycle itself.
- R8: `cfg_err_o` = `cfg_burst_i` AND (any of the four wait fields non-zero). `cfg_burst_i` has no effect on access timing.
- R9: Configuration inputs are captured at acceptance. Changing them during an access does not alter that access.
- R10: A request made while `rdy_o`=0 is ignored and starts no access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Host access request |
| wr_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | ADDR_W | Access address |
| wdata_i | input | DATA_W | Write data |
| rdy_o | output | 1 | Controller can accept a request |
| ack_o | output | 1 | One-cycle access completion |
| rdata_o | output | DATA_W | Read data |
| cfg_rd_coarse_i | input | 2 | Read wait coarse field |
| cfg_rd_fine_i | input | 1 | Read wait fine correction |
| cfg_wr_coarse_i | input | 2 | Write wait coarse field |
| cfg_wr_fine_i | input | 1 | Write wait fine correction |
| cfg_cs_sel_i | input | 2 | Chip-select code, main part |
| cfg_cs_ext_i | input | 1 | Chip-select code, extension bit |
| cfg_gap_i | input | GAP_W | Idle gap between transfers |
| cfg_rate_adj_i | input | 1 | Adds one gap clock in multi-select modes |
| cfg_burst_i | input | 1 | Burst enable (not acted on) |
| cfg_err_o | output | 1 | Burst combined with non-zero wait settings |
| ad_o | output | ADDR_W | Shared bus output value |
| ad_oe_o | output | 1 | Shared bus output enable |
| ad_i | input | ADDR_W | Shared bus input value |
| ale_o | output | 1 | Address latch enable |
| rd_n_o | output | 1 | Read strobe, active low |
| wr_n_o | output | 1 | Write strobe, active low |
| cs_n_o | output | 4 | Chip selects, active low |

## Verification
The assertions assume only that reset is applied once at start-up. They place no constraint on `req_i` or the configuration inputs, because the controller ignores requests while busy and captures its settings at acceptance. The stimulus keeps `ad_i` steady for the whole data phase, as a real device would. Requests are raised only when `rdy_o` is seen high, except in the deliberate busy-time requests that exercise R10. Random settings cover every value of every field, including the unused chip-select codes and burst with non-zero waits.

// File: rtl/hbus_pkg.sv
package hbus_pkg;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_ADDR = 2'd1,
        PH_DATA = 2'd2,
        PH_GAP  = 2'd3
    } phase_e;

    typedef enum logic [1:0] {
        CSM_NONE = 2'd0,
        CSM_TWO  = 2'd1,
        CSM_FOUR = 2'd2
    } cs_mode_e;

    localparam int NUM_CS   = 4;
    localparam int COARSE_W = 2;
    localparam int WAIT_CW  = COARSE_W + 2;

endpackage

// File: rtl/hbus_wait_calc.sv
module hbus_wait_calc
    import hbus_pkg::*;
(
    input  logic [COARSE_W-1:0] coarse_i,
    input  logic                fine_i,
    output logic [WAIT_CW-1:0]  cycles_o
);

    localparam logic [WAIT_CW-1:0] TWO = WAIT_CW'(2);

    // data-phase clocks = 2*coarse + 2 - fine
    always_comb begin
        cycles_o = {1'b0, coarse_i, 1'b0} + TWO - WAIT_CW'(fine_i);
    end

endmodule

// File: rtl/hbus_cs_decode.sv
module hbus_cs_decode
    import hbus_pkg::*;
(
    input  logic [1:0]        sel_i,
    input  logic              ext_i,
    input  logic [1:0]        addr_top_i,
    output logic              multi_o,
    output logic [NUM_CS-1:0] cs_vec_o
);

    cs_mode_e mode;

    always_comb begin
        unique case ({sel_i, ext_i})
            3'b110:  mode = CSM_TWO;
            3'b001:  mode = CSM_FOUR;
            default: mode = CSM_NONE;
        endcase
        multi_o = (mode != CSM_NONE);
    end

    for (genvar i = 0; i < NUM_CS; i++) begin : g_line
        always_comb begin
            cs_vec_o[i] = ((mode == CSM_TWO)  && (i < 2) && (int'(addr_top_i[1]) == i)) ||
                          ((mode == CSM_FOUR) && (int'(addr_top_i) == i));
        end
    end

endmodule

// File: rtl/hbus_seq.sv
module hbus_seq
    import hbus_pkg::*;
#(
    parameter int ADDR_W = 20,
    parameter int DATA_W = 16,
    parameter int GAP_LW = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_i,
    input  logic              wr_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic [WAIT_CW-1:0] rd_cycles_i,
    input  logic [WAIT_CW-1:0] wr_cycles_i,
    input  logic [NUM_CS-1:0] cs_vec_i,
    input  logic [GAP_LW-1:0] gap_len_i,
    input  logic [DATA_W-1:0] rd_bus_i,
    output logic              rdy_o,
    output logic              ack_o,
    output logic [DATA_W-1:0] rdata_o,
    output logic [ADDR_W-1:0] ad_o,
    output logic              ad_oe_o,
    output logic              ale_o,
    output logic              rd_n_o,
    output logic              wr_n_o,
    output logic [NUM_CS-1:0] cs_n_o
);

    localparam int CW = (WAIT_CW > GAP_LW) ? WAIT_CW : GAP_LW;
    localparam logic [CW-1:0] ONE = CW'(1);

    typedef struct packed {
        phase_e              ph;
        logic [CW-1:0]       cnt;
        logic                wr;
        logic [ADDR_W-1:0]   addr;
        logic [DATA_W-1:0]   wdata;
        logic [NUM_CS-1:0]   cs;
        logic [GAP_LW-1:0]   gap;
        logic                ack;
        logic [DATA_W-1:0]   rdata;
    } seq_t;

    seq_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.ack = 1'b0;
        unique case (st_q.ph)
            PH_IDLE: begin
                if (req_i) begin
                    st_d.ph    = PH_ADDR;
                    st_d.wr    = wr_i;
                    st_d.addr  = addr_i;
                    st_d.wdata = wdata_i;
                    st_d.cs    = cs_vec_i;
                    st_d.gap   = gap_len_i;
                    st_d.cnt   = (wr_i ? CW'(wr_cycles_i) : CW'(rd_cycles_i)) - ONE;
                end
            end
            PH_ADDR: begin
                st_d.ph = PH_DATA;
            end
            PH_DATA: begin
                if (st_q.cnt == '0) begin
                    st_d.ack = 1'b1;
                    if (!st_q.wr) begin
                        st_d.rdata = rd_bus_i;
                    end
                    if (st_q.gap == '0) begin
                        st_d.ph = PH_IDLE;
                    end else begin
                        st_d.ph  = PH_GAP;
                        st_d.cnt = CW'(st_q.gap) - ONE;
                    end
                end else begin
                    st_d.cnt = st_q.cnt - ONE;
                end
            end
            PH_GAP: begin
                if (st_q.cnt == '0) begin
                    st_d.ph = PH_IDLE;
                end else begin
                    st_d.cnt = st_q.cnt - ONE;
                end
            end
            default: st_d.ph = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    logic in_addr, in_data;

    always_comb begin
        in_addr = (st_q.ph == PH_ADDR);
        in_data = (st_q.ph == PH_DATA);
        rdy_o   = (st_q.ph == PH_IDLE);
        ack_o   = st_q.ack;
        rdata_o = st_q.rdata;
        ale_o   = in_addr;
        rd_n_o  = !(in_data && !st_q.wr);
        wr_n_o  = !(in_data && st_q.wr);
        ad_oe_o = in_addr || (in_data && st_q.wr);
        if (in_addr) begin
            ad_o = st_q.addr;
        end else if (in_data && st_q.wr) begin
            ad_o = ADDR_W'(st_q.wdata);
        end else begin
            ad_o = '0;
        end
        cs_n_o = (in_addr || in_data) ? ~st_q.cs : '1;
    end

    // R2: address latch enable lasts a single clock
    a_r2_ale_single: assert property (@(posedge clk) disable iff (!rst_n)
        ale_o |=> !ale_o);

    // R2: address latch enable only follows an idle, ready cycle (R10)
    a_r10_ale_after_ready: assert property (@(posedge clk) disable iff (!rst_n)
        ale_o |-> $past(rdy_o));

    // R3: a strobe follows the address cycle directly
    a_r3_strobe_follows_ale: assert property (@(posedge clk) disable iff (!rst_n)
        ale_o |=> (!rd_n_o || !wr_n_o));

    // R3: never both strobes at once
    a_r3_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        rd_n_o || wr_n_o);

    // R4: bus released while reading
    a_r4_read_released: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_n_o |-> !ad_oe_o);

    // R5: acknowledge is a single pulse right after a strobe
    a_r5_ack_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        ack_o |=> !ack_o);
    a_r5_ack_after_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        ack_o |-> ($past(!rd_n_o || !wr_n_o) && rd_n_o && wr_n_o));

    // R6: at most one select active, none while ready
    a_r6_cs_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(~cs_n_o));
    a_r6_cs_idle: assert property (@(posedge clk) disable iff (!rst_n)
        rdy_o |-> (&cs_n_o));

endmodule

// File: rtl/hbus_mux_ctrl.sv
module hbus_mux_ctrl
    import hbus_pkg::*;
#(
    parameter int ADDR_W = 20,
    parameter int DATA_W = 16,
    parameter int GAP_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_i,
    input  logic              wr_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic              rdy_o,
    output logic              ack_o,
    output logic [DATA_W-1:0] rdata_o,
    input  logic [1:0]        cfg_rd_coarse_i,
    input  logic              cfg_rd_fine_i,
    input  logic [1:0]        cfg_wr_coarse_i,
    input  logic              cfg_wr_fine_i,
    input  logic [1:0]        cfg_cs_sel_i,
    input  logic              cfg_cs_ext_i,
    input  logic [GAP_W-1:0]  cfg_gap_i,
    input  logic              cfg_rate_adj_i,
    input  logic              cfg_burst_i,
    output logic              cfg_err_o,
    output logic [ADDR_W-1:0] ad_o,
    output logic              ad_oe_o,
    input  logic [ADDR_W-1:0] ad_i,
    output logic              ale_o,
    output logic              rd_n_o,
    output logic              wr_n_o,
    output logic [3:0]        cs_n_o
);

    localparam int GAP_LW = GAP_W + 1;

    logic [WAIT_CW-1:0] rd_cycles, wr_cycles;
    logic [NUM_CS-1:0]  cs_vec;
    logic               multi;
    logic [GAP_LW-1:0]  gap_len;

    hbus_wait_calc u_rd_wait (
        .coarse_i (cfg_rd_coarse_i),
        .fine_i   (cfg_rd_fine_i),
        .cycles_o (rd_cycles)
    );

    hbus_wait_calc u_wr_wait (
        .coarse_i (cfg_wr_coarse_i),
        .fine_i   (cfg_wr_fine_i),
        .cycles_o (wr_cycles)
    );

    hbus_cs_decode u_cs (
        .sel_i      (cfg_cs_sel_i),
        .ext_i      (cfg_cs_ext_i),
        .addr_top_i (addr_i[ADDR_W-1 -: 2]),
        .multi_o    (multi),
        .cs_vec_o   (cs_vec)
    );

    always_comb begin
        gap_len   = {1'b0, cfg_gap_i} + {{GAP_W{1'b0}}, (cfg_rate_adj_i & multi)};
        cfg_err_o = cfg_burst_i &
                    (|{cfg_rd_coarse_i, cfg_rd_fine_i, cfg_wr_coarse_i, cfg_wr_fine_i});
    end

    if (DATA_W < ADDR_W) begin : g_upper
        logic unused_upper;
        assign unused_upper = ^ad_i[ADDR_W-1:DATA_W];
    end

    hbus_seq #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W),
        .GAP_LW (GAP_LW)
    ) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_i       (req_i),
        .wr_i        (wr_i),
        .addr_i      (addr_i),
        .wdata_i     (wdata_i),
        .rd_cycles_i (rd_cycles),
        .wr_cycles_i (wr_cycles),
        .cs_vec_i    (cs_vec),
        .gap_len_i   (gap_len),
        .rd_bus_i    (ad_i[DATA_W-1:0]),
        .rdy_o       (rdy_o),
        .ack_o       (ack_o),
        .rdata_o     (rdata_o),
        .ad_o        (ad_o),
        .ad_oe_o     (ad_oe_o),
        .ale_o       (ale_o),
        .rd_n_o      (rd_n_o),
        .wr_n_o      (wr_n_o),
        .cs_n_o      (cs_n_o)
    );

    // R8: an error needs burst to be requested
    a_r8_err_needs_burst: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_err_o |-> cfg_burst_i);

endmodule

// File: tb/hbus_mux_ctrl_test.sv
`timescale 1ns/1ps
module hbus_mux_ctrl_test;

    localparam int AW = 20;
    localparam int DW = 16;
    localparam int GW = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req = 1'b0, wr = 1'b0;
    logic [AW-1:0] addr = '0, ad_in = '0;
    logic [DW-1:0] wdata = '0;
    logic [1:0] rdc = '0, wrc = '0, sel = '0;
    logic rdf = 1'b0, wrf = 1'b0, ext = 1'b0, rate = 1'b0, burst = 1'b0;
    logic [GW-1:0] gap = '0;

    logic rdy, ack, err, ad_oe, ale, rd_n, wr_n;
    logic [DW-1:0] rdata;
    logic [AW-1:0] ad_out;
    logic [3:0] cs_n;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    hbus_mux_ctrl #(.ADDR_W(AW), .DATA_W(DW), .GAP_W(GW)) uut (
        .clk(clk), .rst_n(rst_n), .req_i(req), .wr_i(wr), .addr_i(addr),
        .wdata_i(wdata), .rdy_o(rdy), .ack_o(ack), .rdata_o(rdata),
        .cfg_rd_coarse_i(rdc), .cfg_rd_fine_i(rdf), .cfg_wr_coarse_i(wrc),
        .cfg_wr_fine_i(wrf), .cfg_cs_sel_i(sel), .cfg_cs_ext_i(ext),
        .cfg_gap_i(gap), .cfg_rate_adj_i(rate), .cfg_burst_i(burst),
        .cfg_err_o(err), .ad_o(ad_out), .ad_oe_o(ad_oe), .ad_i(ad_in),
        .ale_o(ale), .rd_n_o(rd_n), .wr_n_o(wr_n), .cs_n_o(cs_n)
    );

    task automatic chk(input bit ok, input string rq, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual=%0h expected=%0h", rq, what, act, exp);
        end
    endtask

    function automatic int exp_wait(input logic [1:0] c, input logic f);
        return 2 * int'(c) + 2 - int'(f);
    endfunction

    function automatic bit is_multi(input logic [1:0] s, input logic e);
        return (s == 2'd3 && !e) || (s == 2'd0 && e);
    endfunction

    function automatic int exp_gap(input logic [GW-1:0] g, input logic r,
                                   input logic [1:0] s, input logic e);
        return int'(g) + ((r && is_multi(s, e)) ? 1 : 0);
    endfunction

    function automatic logic [3:0] exp_cs_n(input logic [1:0] s, input logic e,
                                            input logic [AW-1:0] a);
        logic [3:0] v;
        v = 4'b1111;
        if (s == 2'd3 && !e) v[a[AW-1]] = 1'b0;
        else if (s == 2'd0 && e) v[a[AW-1:AW-2]] = 1'b0;
        return v;
    endfunction

    function automatic bit exp_err(input logic b, input logic [1:0] c1, input logic f1,
                                   input logic [1:0] c2, input logic f2);
        return b && (c1 != 0 || f1 || c2 != 0 || f2);
    endfunction

    task automatic cfg_random();
        rdc   = 2'($urandom_range(0, 3));
        wrc   = 2'($urandom_range(0, 3));
        rdf   = 1'($urandom_range(0, 1));
        wrf   = 1'($urandom_range(0, 1));
        sel   = 2'($urandom_range(0, 3));
        ext   = 1'($urandom_range(0, 1));
        gap   = GW'($urandom_range(0, 15));
        rate  = 1'($urandom_range(0, 1));
        burst = 1'($urandom_range(0, 1));
    endtask

    // one access; all expected values computed before it starts
    task automatic run_access(input logic w, input logic [AW-1:0] a,
                              input logic [DW-1:0] wd, input logic [AW-1:0] rv,
                              input bit hammer, input bit swap);
        int n_exp, g_exp, k, ale_n, ale_k, stb_n, stb_first, ack_n, ack_k, rdy_k;
        bit bad_addr, bad_data, bad_kind, bad_cs;
        logic [3:0] cs_exp;
        logic [DW-1:0] got;
        n_exp = w ? exp_wait(wrc, wrf) : exp_wait(rdc, rdf);
        g_exp = exp_gap(gap, rate, sel, ext);
        cs_exp = exp_cs_n(sel, ext, a);
        #1;
        chk(err == exp_err(burst, rdc, rdf, wrc, wrf), "R8", "cfg_err",
            longint'(err), longint'(exp_err(burst, rdc, rdf, wrc, wrf)));
        while (!rdy) @(negedge clk);
        req = 1'b1; wr = w; addr = a; wdata = wd; ad_in = rv;
        @(negedge clk);
        req = hammer;
        if (swap) cfg_random();   // R9: must not alter this access
        k = 0; ale_n = 0; ale_k = -1; stb_n = 0; stb_first = -1;
        ack_n = 0; ack_k = -1; rdy_k = -1; got = '0;
        bad_addr = 0; bad_data = 0; bad_kind = 0; bad_cs = 0;
        while (k < 64) begin
            if (ale) begin
                ale_n++; if (ale_k < 0) ale_k = k;
                if (ad_out !== a || !ad_oe) bad_addr = 1;
            end
            if (!rd_n || !wr_n) begin
                stb_n++; if (stb_first < 0) stb_first = k;
                if (w ? (wr_n || !rd_n) : (rd_n || !wr_n)) bad_kind = 1;
                if (w ? (!ad_oe || ad_out !== {{(AW-DW){1'b0}}, wd}) : ad_oe) bad_data = 1;
            end
            if (ale || !rd_n || !wr_n) begin
                if (cs_n !== cs_exp) bad_cs = 1;
            end else if (cs_n !== 4'b1111) bad_cs = 1;
            if (ack) begin ack_n++; ack_k = k; got = rdata; end
            if (rdy) begin rdy_k = k; req = 1'b0; break; end
            @(negedge clk);
            k++;
        end
        chk(ale_n == 1 && ale_k == 0, "R2", "ale count/position", longint'(ale_n), 1);
        chk(!bad_addr, "R2", "address on bus", longint'(ad_out), longint'(a));
        chk(stb_n == n_exp && stb_first == 1, "R3", "strobe cycles", longint'(stb_n), longint'(n_exp));
        chk(!bad_kind, "R3", "strobe kind", longint'(w), longint'(w));
        chk(!bad_data, "R4", "data phase bus", longint'(ad_oe), longint'(w));
        chk(ack_n == 1 && ack_k == n_exp + 1, "R5", "ack position", longint'(ack_k), longint'(n_exp + 1));
        if (!w) chk(got == rv[DW-1:0], "R5", "read data", longint'(got), longint'(rv[DW-1:0]));
        chk(!bad_cs, "R6", "chip selects", longint'(cs_n), longint'(cs_exp));
        chk(rdy_k == n_exp + 1 + g_exp, "R7", "ready return", longint'(rdy_k), longint'(n_exp + 1 + g_exp));
        if (hammer) begin
            @(negedge clk);
            chk(!ale && rdy, "R10", "busy request ignored", longint'(ale), 0);
        end
    endtask

    task automatic set_cfg(input logic [1:0] c_r, input logic f_r, input logic [1:0] c_w,
                           input logic f_w, input logic [1:0] s, input logic e,
                           input logic [GW-1:0] g, input logic r, input logic b);
        rdc = c_r; rdf = f_r; wrc = c_w; wrf = f_w; sel = s; ext = e;
        gap = g; rate = r; burst = b;
    endtask

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(rdy && !ale && rd_n && wr_n && !ack && !ad_oe && cs_n == 4'hF, "R1",
            "reset outputs", longint'({rdy, ale, rd_n, wr_n, ack, ad_oe, cs_n}),
            longint'({1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 4'hF}));

        // R3 shortest read, ALE-only mode, no gap
        set_cfg(2'd0, 1'b1, 2'd0, 1'b1, 2'd0, 1'b0, 4'd0, 1'b0, 1'b0);
        run_access(1'b0, 20'h12345, 16'h0, 20'h0BEEF, 0, 0);
        // R3 longest write, two selects, upper half -> cs_n 4'b1101
        set_cfg(2'd0, 1'b0, 2'd3, 1'b0, 2'd3, 1'b0, 4'd2, 1'b0, 1'b0);
        run_access(1'b1, 20'h8ABCD, 16'hA5C3, 20'h0, 0, 0);
        // R6 four selects, top bits 2'b10 -> cs_n 4'b1011; R7 rate adjust adds one
        set_cfg(2'd2, 1'b1, 2'd1, 1'b0, 2'd0, 1'b1, 4'd3, 1'b1, 1'b0);
        run_access(1'b0, 20'hA0F0F, 16'h0, 20'h05A5A, 0, 0);
        // R7 rate adjust without multiple selects: no extra clock
        set_cfg(2'd1, 1'b1, 2'd1, 1'b1, 2'd0, 1'b0, 4'd5, 1'b1, 1'b0);
        run_access(1'b1, 20'h00010, 16'h1234, 20'h0, 0, 0);
        // R6 unused code {1,0} gives no select
        set_cfg(2'd1, 1'b0, 2'd1, 1'b0, 2'd1, 1'b0, 4'd1, 1'b1, 1'b0);
        run_access(1'b0, 20'hFFFFF, 16'h0, 20'h0FFFF, 0, 0);
        // R10 requests during busy time
        set_cfg(2'd2, 1'b0, 2'd2, 1'b0, 2'd3, 1'b0, 4'd4, 1'b0, 1'b0);
        run_access(1'b1, 20'h40000, 16'h5555, 20'h0, 1, 0);
        // R9 configuration changed right after acceptance
        set_cfg(2'd3, 1'b1, 2'd0, 1'b1, 2'd0, 1'b1, 4'd6, 1'b1, 1'b0);
        run_access(1'b0, 20'hC1234, 16'h0, 20'h07E7E, 0, 1);
        // R8 burst with waits flags error, timing unchanged
        set_cfg(2'd1, 1'b0, 2'd0, 1'b1, 2'd0, 1'b0, 4'd0, 1'b0, 1'b1);
        run_access(1'b1, 20'h00F00, 16'hBEEF, 20'h0, 0, 0);
        // R8 burst with all-zero waits: no error
        set_cfg(2'd0, 1'b0, 2'd0, 1'b0, 2'd0, 1'b0, 4'd0, 1'b0, 1'b1);
        run_access(1'b0, 20'h00F01, 16'h0, 20'h03C3C, 0, 0);

        // random mix over all fields
        for (int i = 0; i < 200; i++) begin
            cfg_random();
            run_access(1'($urandom_range(0, 1)), AW'($urandom), DW'($urandom),
                       AW'($urandom), ($urandom_range(0, 7) == 0),
                       ($urandom_range(0, 3) == 0));
        end

        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        #(4 * 200000);
        if (!done) begin
            done = 1'b1;
            checks++;
            fails++;
            $display("FAIL watchdog: actual=%0h expected=%0h", 1, 0);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule